// File: doc/BRIEF.md
# Lockable Clock-Multiplier Control with Feedback Divider

This block holds the programming byte for a phase-locked clock multiplier and runs the modulo-N feedback divider that the multiplier code drives. The byte has two four-bit fields. The upper field selects the feedback divide ratio N. The lower field selects the oscillator range, and the block drives that field straight out to the analog side. A byte-wide bus with separate read and write strobes reaches the register. The oscillator, phase comparator and loop filter stay outside the block.

A PLL-enable input locks the byte. While the input is high, the block discards every bus write, so software cannot change the ratio or the range while the loop is running. The divider counts clock cycles and emits one single-cycle pulse every N cycles. A multiplier code of zero divides exactly as a code of one does. The divider loads a new ratio only when it reloads, so a period already in progress always finishes at its old length.

Top module: `clkmul_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the register takes the value 0x66 (multiplier code 6, range code 6), fb_pulse_o goes low and the divider count clears.
- R2: Bits 7:4 of the register are the multiplier code and bits 3:0 are the range code. range_sel_o always shows bits 3:0.
- R3: When bus_wr_i is high and pll_en_i is low at a clock edge, the whole byte bus_wdata_i is written into the register at that edge.
- R4: When pll_en_i is high at a clock edge, a write at that edge leaves both fields unchanged. This includes the edge at which pll_en_i first rises.
- R5: While bus_rd_i is high, bus_rdata_o shows the register contents in the same cycle. While bus_rd_i is low, bus_rdata_o is 0x00. Reads never change any state.
- R6: For multiplier codes 1 to 15, fb_pulse_o is high for one cycle out of every N cycles, where N equals the code.
- R7: A multiplier code of 0 divides by 1, exactly as code 1 does: fb_pulse_o stays high on every cycle.
- R8: The divider samples the multiplier code only at the edge where it reloads. A code change therefore alters the period only from the next pulse onward.
- R9: At the first clock edge with rst_n high after a reset, the divider reloads and fb_pulse_o goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the input clock that the divider counts |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rd_i is high |
| pll_en_i | input | 1 | PLL enable; locks the register while high |
| range_sel_o | output | 4 | Oscillator range code |
| fb_pulse_o | output | 1 | Feedback divider output pulse |

## Verification
The bound checker tests the following on every cycle:
- Writes are dropped while pll_en_i is high.
- An unlocked write lands at the next edge, and the range output holds still when no write occurs.
- Read data agrees with the range output.
- Pulses repeat back to back for codes 0 and 1, and a pulse is followed by a low cycle for larger codes.

The exact period for each code, the first pulse after reset, and the rule that a new code waits for the next reload all depend on history. Only the bench's cycle-accurate reference model shows them, using mixed random and directed traffic.

// File: rtl/clkmul_pkg.sv
// Package: shared widths, reset codes and the ratio helper for the
// clock-multiplier control block. Assumes two equal-width fields per byte.
package clkmul_pkg;
    localparam int FIELD_W = 4;
    localparam int REG_W   = 2 * FIELD_W;
    localparam logic [FIELD_W-1:0] MULT_RST  = 4'h6;
    localparam logic [FIELD_W-1:0] RANGE_RST = 4'h6;

    // Maps a multiplier code to its divide ratio; code zero acts as one.
    function automatic logic [FIELD_W-1:0] eff_ratio(input logic [FIELD_W-1:0] code);
        return (code == '0) ? FIELD_W'(1) : code;
    endfunction
endpackage

// File: rtl/clkmul_reg.sv
// Module: lockable programming register. Holds NFIELDS fields of FW bits,
// each with its own reset code. Any write is dropped while lock_i is high.
// Assumes write data and lock are synchronous to clk.
module clkmul_reg #(
    parameter int FW      = 4,
    parameter int NFIELDS = 2,
    parameter logic [FW*NFIELDS-1:0] RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  lock_i,
    input  logic [FW*NFIELDS-1:0] wdata_i,
    output logic [FW*NFIELDS-1:0] q_o
);
    logic wr_ok;

    // Write qualification: protection wins over any strobe in the same cycle.
    always_comb wr_ok = wr_i && !lock_i;

    for (genvar f = 0; f < NFIELDS; f++) begin : g_field
        logic [FW-1:0] fld_q;

        // Field storage: reset code, else take write data when unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_q <= RST_VAL[f*FW +: FW];
            else if (wr_ok)
                fld_q <= wdata_i[f*FW +: FW];
        end

        assign q_o[f*FW +: FW] = fld_q;
    end
endmodule

// File: rtl/clkmul_div.sv
// Module: modulo-N feedback divider. Counts clock cycles and gives one
// registered pulse per N cycles. It samples the ratio only at reload, so a
// running period is never cut short. Assumes ratio_i is already nonzero.
module clkmul_div #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] ratio_i,
    output logic          pulse_o
);
    logic [FW-1:0] cnt_q;
    logic          term;

    // Terminal detect: the count has run down to one, or it is idle after reset.
    always_comb term = (cnt_q <= FW'(1));

    // Counter and pulse: reload the ratio at terminal, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (term) begin
            cnt_q   <= ratio_i;
            pulse_o <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - FW'(1);
            pulse_o <= 1'b0;
        end
    end
endmodule

// File: rtl/clkmul_ctrl.sv
// Module: top of the clock-multiplier control. A byte register on a simple
// strobe bus feeds the range output and drives the feedback divider. The
// register locks while the PLL is enabled. Assumes a single clock domain.
module clkmul_ctrl
    import clkmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    input  logic             pll_en_i,
    output logic [FIELD_W-1:0] range_sel_o,
    output logic             fb_pulse_o
);
    logic [REG_W-1:0]   cfg_q;
    logic [FIELD_W-1:0] ratio;

    clkmul_reg #(
        .FW      (FIELD_W),
        .NFIELDS (2),
        .RST_VAL ({MULT_RST, RANGE_RST})
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .lock_i  (pll_en_i),
        .wdata_i (bus_wdata_i),
        .q_o     (cfg_q)
    );

    // Ratio decode: fold multiplier code zero onto one.
    always_comb ratio = eff_ratio(cfg_q[REG_W-1 -: FIELD_W]);

    clkmul_div #(.FW(FIELD_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (ratio),
        .pulse_o (fb_pulse_o)
    );

    // Read mux: contents while strobed, zero otherwise.
    always_comb bus_rdata_o = bus_rd_i ? cfg_q : '0;

    // Range output: lower field straight to the analog side.
    always_comb range_sel_o = cfg_q[FIELD_W-1:0];
endmodule

// File: rtl/clkmul_ctrl_chk.sv
// Checker: temporal properties of clkmul_ctrl, attached by bind below.
module clkmul_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic       rd,
    input logic       en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [3:0] range_sel,
    input logic [7:0] cfg,
    input logic       pulse
);
    // R4: a write under lock changes nothing
    a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && en) |=> $stable(cfg));

    // R3: an unlocked write lands at the next edge
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !en) |=> (cfg == $past(wdata)));

    // R2: range output moves only on a write
    a_r2_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(range_sel));

    // R5: read data agrees with the range output
    a_r5_read_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> (rdata[3:0] == range_sel));

    // R7: codes 0 and 1 give back-to-back pulses
    a_r7_div_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pulse && ($past(cfg[7:4]) <= 4'd1)) |=> pulse);

    // R6: for ratios of two or more, a pulse is followed by a low cycle
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pulse && ($past(cfg[7:4]) >= 4'd2)) |=> !pulse);
endmodule

bind clkmul_ctrl clkmul_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr_i),
    .rd        (bus_rd_i),
    .en        (pll_en_i),
    .wdata     (bus_wdata_i),
    .rdata     (bus_rdata_o),
    .range_sel (range_sel_o),
    .cfg       (cfg_q),
    .pulse     (fb_pulse_o)
);

// File: tb/test_clkmul_ctrl.sv
module test_clkmul_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr_i = 1'b0;
    logic       bus_rd_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       pll_en_i = 1'b0;
    logic [3:0] range_sel_o;
    logic       fb_pulse_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_reg;
    int         exp_rem;
    logic       exp_pulse;

    always #5 clk = ~clk;

    clkmul_ctrl i_clkmul_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pll_en_i(pll_en_i),
        .range_sel_o(range_sel_o), .fb_pulse_o(fb_pulse_o)
    );

    function automatic int ratio_of(input logic [3:0] code);
        return (code == 4'd0) ? 1 : int'(code);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at negedge, check read data, then update the model and check after the edge.
    task automatic step(input logic rst, input logic wr, input logic rd,
                        input logic [7:0] d, input logic en);
        @(negedge clk);
        rst_n = rst; bus_wr_i = wr; bus_rd_i = rd; bus_wdata_i = d; pll_en_i = en;
        #1;
        if (rst) check("R5 rdata", bus_rdata_o, rd ? exp_reg : 8'h00);
        @(posedge clk);
        if (!rst) begin
            exp_reg = 8'h66; exp_rem = 0; exp_pulse = 1'b0;
        end else begin
            if (exp_rem <= 1) begin
                exp_pulse = 1'b1;
                exp_rem = ratio_of(exp_reg[7:4]);
            end else begin
                exp_pulse = 1'b0;
                exp_rem--;
            end
            if (wr && !en) exp_reg = d;
        end
        #1;
        check("R6/R7/R8/R9 fb_pulse", fb_pulse_o, exp_pulse);
        check("R2/R3/R4 range_sel", range_sel_o, exp_reg[3:0]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h1bad5eed;
        void'($urandom(seed));
        exp_reg = 8'h66; exp_rem = 0; exp_pulse = 1'b0;
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b1, 1'b0, 8'hff, 1'b0);
        // R1: reset value and quiet divider
        check("R1 pulse low in reset", fb_pulse_o, 1'b0);
        check("R1 range reset", range_sel_o, 4'h6);
        // R9: first edge out of reset pulses
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
        check("R9 first pulse", fb_pulse_o, 1'b1);
        check("R1 R2 reset read", bus_rdata_o, 8'h66);
        repeat (14) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        // R3: unlocked write, code 3 range 9
        step(1'b1, 1'b1, 1'b0, 8'h39, 1'b0);
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
        check("R3 write readback", bus_rdata_o, 8'h39);
        repeat (12) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        // R4: write dropped on the edge where the enable rises
        step(1'b1, 1'b1, 1'b0, 8'hA5, 1'b1);
        step(1'b1, 1'b1, 1'b1, 8'h5A, 1'b1);
        check("R4 locked readback", bus_rdata_o, 8'h39);
        // R7: code 0 gives a pulse every cycle
        step(1'b1, 1'b1, 1'b0, 8'h02, 1'b0);
        repeat (8) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        // R6/R8: code 15, then shorten it in mid-count
        step(1'b1, 1'b1, 1'b0, 8'hF0, 1'b0);
        repeat (20) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b1, 1'b0, 8'h21, 1'b0);
        repeat (20) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b1, 1'b0, 8'h1C, 1'b0);
        repeat (6) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        // Random mix covering R2 to R8
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[31:28] != 4'h0, r[0] & r[1] & r[2], r[3], r[15:8], r[4] & r[5]);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule